// File: doc/BRIEF.md
# Fuse Array Register Front End

This block sits between a simple single-cycle register bus and a one-time-programmable fuse array. Software uses it to read a local shadow copy of every fuse word and to burn new bits into one word at a time. It also copies the whole array back into the shadow copy. A program operation only starts if software first arms it with a key written beside the word address. Any forbidden access, such as touching a locked word or issuing a request while one is running, raises a sticky error flag. That flag blocks further traffic until software clears it.

The fuse array sits behind a request/done handshake. The front end drives the request, the word index, the program data and a timing word. The array answers with a one-cycle done pulse, and for read operations it also returns the word together with its write-lock and read-lock flags. The shadow copy and its lock flags live in a register file inside the block. Coming out of reset, the block copies every word once from the array on its own.

A parameter picks the banked variant. In that variant four data registers are staged, the address field names a group of four consecutive words, and the write to the first data register programs all four words in order. The sequencer has three states. IDLE moves to PROGRAM on an accepted armed write, and to RELOAD on an accepted copy request. PROGRAM steps through one or four words and returns to IDLE on the done pulse of the last one. RELOAD steps through every word and returns to IDLE on the last done pulse. Reset enters RELOAD.

Top module: `otp_ctl_frontend`

## Requirements
- R1: Reset enters RELOAD. The control word at offset 0x000 reads busy (bit 8) and copy-in-progress (bit 10) as 1 until every word has been copied. After that the control word reads 0.
- R2: A read at offset 0x400 + 16*i returns shadow word i. If word i is read-locked, the read returns 0xBADABADA and sets the error flag (control bit 9).
- R3: A write to the data register at 0x020 starts programming only if the control word's bits [31:16] hold 0x3E77. When programming starts, busy rises and the key field reads 0. Without the key, the write only stores the data and no fuse request is made.
- R4: The word index and data are captured when programming starts. Writing the address field (control bits [6:0]) while busy does not change the word being programmed.
- R5: Once the request is raised, the request, word index and program data stay unchanged until the done pulse.
- R6: An armed program of a write-locked word makes no fuse request and leaves busy at 0. It sets the error flag and clears the key.
- R7: The error flag stays set until a 1 is written to bit 9 at offset 0x008. While it is set, control writes, data writes, shadow writes and copy requests have no effect, and shadow reads return 0xBADABADA.
- R8: Writing a 1 to bit 10 at offset 0x004 starts a copy of all words into the shadow file. Programmed bits appear in the shadow word only after such a copy.
- R9: A write to the data register at 0x020 or a copy request while busy is dropped and sets the error flag. Data register contents are not changed while busy.
- R10: A shadow write updates the word. A shadow write to a write-locked word, or one made during a copy, sets the error flag and leaves the word unchanged.
- R11: In the banked variant, a group number g in the address field makes an armed write at 0x020 program words 4g..4g+3 in that order. Those words receive the data registers at 0x020, 0x030, 0x040 and 0x050. If any of the four words is write-locked, the block raises the error flag and makes no request.
- R12: The timing register at 0x010 reads back what was written and drives `fuse_timing`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| fuse_req | output | 1 | Request to the fuse array |
| fuse_prog | output | 1 | 1 = program, 0 = read |
| fuse_addr | output | 7 | Fuse word index |
| fuse_wdata | output | 32 | Bits to burn |
| fuse_timing | output | 32 | Timing register contents |
| fuse_done | input | 1 | One-cycle completion pulse |
| fuse_rdata | input | 32 | Word read from the array |
| fuse_wlock | input | 1 | Word is write-locked |
| fuse_rlock | input | 1 | Word is read-locked |

## Verification
The bench builds two instances with a 16-word array: one unbanked and one banked (BANKED=1). The small array keeps each full copy down to a few dozen cycles, so several reloads fit into short directed scenarios. It also lets the bench place a write-locked word inside the third group of four. The banked instance is what makes the four-word program order and the group lock refusal observable.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;
    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_SET    = 12'h004;
    localparam logic [11:0] OFS_CLR    = 12'h008;
    localparam logic [11:0] OFS_TIME   = 12'h010;
    localparam logic [11:0] OFS_DATA0  = 12'h020;
    localparam logic [11:0] OFS_SHADOW = 12'h400;
    localparam logic [15:0] ARM_KEY    = 16'h3E77;
    localparam logic [31:0] POISON     = 32'hBADABADA;
    localparam int BIT_BUSY = 8;
    localparam int BIT_ERR  = 9;
    localparam int BIT_RLD  = 10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROG,
        SQ_RELOAD
    } seq_state_t;
endpackage

// File: rtl/otp_ctl_shadow.sv
module otp_ctl_shadow #(
    parameter int WORDS = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [31:0]      cap_data,
    input  logic             cap_wl,
    input  logic             cap_rl,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [31:0]      sw_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             rd_rl,
    output logic             rd_wl,
    output logic [WORDS-1:0] wl_vec
);
    logic [31:0]      word_q [WORDS];
    logic [WORDS-1:0] wl_q;
    logic [WORDS-1:0] rl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
            wl_q <= '0;
            rl_q <= '0;
        end else if (cap_en) begin
            word_q[cap_idx] <= cap_data;
            wl_q[cap_idx]   <= cap_wl;
            rl_q[cap_idx]   <= cap_rl;
        end else if (sw_en) begin
            word_q[sw_idx] <= sw_data;
        end
    end

    assign rd_data = word_q[rd_idx];
    assign rd_rl   = rl_q[rd_idx];
    assign rd_wl   = wl_q[rd_idx];
    assign wl_vec  = wl_q;
endmodule

// File: rtl/otp_ctl_seq.sv
module otp_ctl_seq
    import otp_ctl_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int LANES = 1,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_prog,
    input  logic                  go_reload,
    input  logic [IDX_W-1:0]      base_idx,
    input  logic [LANES*32-1:0]   lane_data,
    output logic                  busy,
    output logic                  reloading,
    output logic                  fuse_req,
    output logic                  fuse_prog,
    output logic [6:0]            fuse_addr,
    output logic [31:0]           fuse_wdata,
    input  logic                  fuse_done,
    output logic                  cap_en,
    output logic [IDX_W-1:0]      cap_idx
);
    seq_state_t       state_q, nxt;
    logic [IDX_W-1:0] cnt_q, base_q, cur_idx;
    logic             last;
    logic [31:0]      lane_word;

    assign last = (state_q == SQ_PROG) ? (cnt_q == IDX_W'(LANES-1))
                                       : (cnt_q == IDX_W'(WORDS-1));

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (go_reload)    nxt = SQ_RELOAD;
                else if (go_prog) nxt = SQ_PROG;
            end
            SQ_PROG, SQ_RELOAD: begin
                if (fuse_done && last) nxt = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_RELOAD;
            cnt_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= nxt;
            if (state_q == SQ_IDLE) begin
                cnt_q <= '0;
                if (go_prog) base_q <= base_idx;
            end else if (fuse_done) begin
                cnt_q <= last ? '0 : cnt_q + 1'b1;
            end
        end
    end

    generate
        if (LANES == 1) begin : g_single
            assign lane_word = lane_data[31:0];
        end else begin : g_banked
            localparam int LANE_W = $clog2(LANES);
            assign lane_word = lane_data[cnt_q[LANE_W-1:0]*32 +: 32];
        end
    endgenerate

    always_comb begin
        busy       = (state_q != SQ_IDLE);
        reloading  = (state_q == SQ_RELOAD);
        fuse_req   = busy;
        fuse_prog  = (state_q == SQ_PROG);
        cur_idx    = fuse_prog ? base_q + cnt_q : cnt_q;
        fuse_addr  = 7'(cur_idx);
        fuse_wdata = fuse_prog ? lane_word : '0;
        cap_en     = reloading && fuse_done;
        cap_idx    = cnt_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req && !fuse_done |=> fuse_req && $stable(fuse_addr) && $stable(fuse_wdata)); // R5
endmodule

// File: rtl/otp_ctl_frontend.sv
module otp_ctl_frontend
    import otp_ctl_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int BANKED = 0,
    localparam int IDX_W = $clog2(WORDS),
    localparam int LANES = (BANKED != 0) ? 4 : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        fuse_req,
    output logic        fuse_prog,
    output logic [6:0]  fuse_addr,
    output logic [31:0] fuse_wdata,
    output logic [31:0] fuse_timing,
    input  logic        fuse_done,
    input  logic [31:0] fuse_rdata,
    input  logic        fuse_wlock,
    input  logic        fuse_rlock
);
    logic             wr_en, rd_en;
    logic             hit_ctrl, hit_set, hit_clr, hit_time, hit_sh;
    logic [3:0]       hit_data;
    logic [11:0]      sh_off;
    logic [IDX_W-1:0] sh_idx, base_idx, cap_idx;
    logic [6:0]       addr_q;
    logic [15:0]      key_q;
    logic             err_q;
    logic [31:0]      time_q;
    logic [31:0]      stage_q [LANES];
    logic [LANES*32-1:0] lane_bus;
    logic             busy, reloading, cap_en;
    logic [31:0]      sh_rdata;
    logic             sh_rl, sh_wl, lock_hit, armed;
    logic [WORDS-1:0] wl_vec;
    logic             ev_ctrl, ev_rld, ev_clr, ev_d0, ev_shw;
    logic             go_prog, go_reload, sh_we, err_set;

    assign wr_en    = bus_sel & bus_wr;
    assign rd_en    = bus_sel & ~bus_wr;
    assign hit_ctrl = (bus_addr == OFS_CTRL);
    assign hit_set  = (bus_addr == OFS_SET);
    assign hit_clr  = (bus_addr == OFS_CLR);
    assign hit_time = (bus_addr == OFS_TIME);
    assign sh_off   = bus_addr - OFS_SHADOW;
    assign hit_sh   = (bus_addr >= OFS_SHADOW) && (sh_off[3:0] == 4'd0)
                      && (sh_off[11:4] < 8'(WORDS));
    assign sh_idx   = sh_off[IDX_W+3:4];

    always_comb begin
        for (int k = 0; k < 4; k++)
            hit_data[k] = (bus_addr == OFS_DATA0 + 12'(k*16));
        for (int k = 0; k < LANES; k++)
            lane_bus[k*32 +: 32] = stage_q[k];
    end

    generate
        if (BANKED != 0) begin : g_group
            assign base_idx = {addr_q[IDX_W-3:0], 2'b00};
        end else begin : g_word
            assign base_idx = addr_q[IDX_W-1:0];
        end
    endgenerate

    always_comb begin
        lock_hit = 1'b0;
        for (int k = 0; k < LANES; k++)
            lock_hit = lock_hit | wl_vec[base_idx + IDX_W'(k)];
    end

    assign armed     = (key_q == ARM_KEY);
    assign ev_ctrl   = wr_en & hit_ctrl & ~err_q;
    assign ev_rld    = wr_en & hit_set & bus_wdata[BIT_RLD] & ~err_q;
    assign ev_clr    = wr_en & hit_clr & bus_wdata[BIT_ERR];
    assign ev_d0     = wr_en & hit_data[0] & ~err_q;
    assign ev_shw    = wr_en & hit_sh & ~err_q;
    assign go_prog   = ev_d0 & ~busy & armed & ~lock_hit;
    assign go_reload = ev_rld & ~busy;
    assign sh_we     = ev_shw & ~reloading & ~sh_wl;
    assign err_set   = (ev_rld & busy) | (ev_d0 & busy)
                     | (ev_d0 & ~busy & armed & lock_hit)
                     | (ev_shw & (reloading | sh_wl))
                     | (rd_en & hit_sh & ~err_q & sh_rl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            key_q  <= '0;
            err_q  <= 1'b0;
            time_q <= '0;
            for (int k = 0; k < LANES; k++) stage_q[k] <= '0;
        end else begin
            if (ev_clr)       err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
            if (ev_ctrl) begin
                addr_q <= bus_wdata[6:0];
                key_q  <= bus_wdata[31:16];
            end
            if (wr_en && hit_time) time_q <= bus_wdata;
            if (ev_d0 && !busy) begin
                stage_q[0] <= bus_wdata;
                if (armed) key_q <= '0;
            end
            for (int k = 1; k < LANES; k++)
                if (wr_en && hit_data[k] && !err_q && !busy) stage_q[k] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl || hit_set || hit_clr)
            bus_rdata = {key_q, 5'd0, reloading, err_q, busy, 1'b0, addr_q};
        else if (hit_time)
            bus_rdata = time_q;
        else if (hit_sh)
            bus_rdata = (err_q || sh_rl) ? POISON : sh_rdata;
        else
            for (int k = 0; k < LANES; k++)
                if (hit_data[k]) bus_rdata = stage_q[k];
    end

    assign fuse_timing = time_q;

    otp_ctl_shadow #(.WORDS(WORDS)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(fuse_rdata),
        .cap_wl(fuse_wlock), .cap_rl(fuse_rlock),
        .sw_en(sh_we), .sw_idx(sh_idx), .sw_data(bus_wdata),
        .rd_idx(sh_idx), .rd_data(sh_rdata), .rd_rl(sh_rl), .rd_wl(sh_wl),
        .wl_vec(wl_vec)
    );

    otp_ctl_seq #(.WORDS(WORDS), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go_prog(go_prog), .go_reload(go_reload), .base_idx(base_idx),
        .lane_data(lane_bus), .busy(busy), .reloading(reloading),
        .fuse_req(fuse_req), .fuse_prog(fuse_prog), .fuse_addr(fuse_addr),
        .fuse_wdata(fuse_wdata), .fuse_done(fuse_done),
        .cap_en(cap_en), .cap_idx(cap_idx)
    );

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !ev_clr |=> err_q); // R7
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !busy |=> !busy); // R7
    AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !reloading |-> key_q == '0); // R3
    AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d0 && !busy && armed && lock_hit |=> err_q && !busy); // R6
    AST_OVERLAP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d0 && busy |=> err_q); // R9
endmodule

// File: tb/test_otp_ctl_frontend.sv
module otp_fuse_model #(
    parameter int WORDS = 16,
    parameter int LAT   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        prog,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    output logic        done,
    output logic [31:0] rdata,
    output logic        wl,
    output logic        rl
);
    logic [31:0] mem [WORDS];
    int          cnt;
    int          prog_n;
    int          viol;
    logic [6:0]  log_addr [16];
    logic [31:0] log_data [16];
    logic        pend;
    logic [6:0]  paddr;

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = 32'h1000_0000 | (i << 8) | i;
        prog_n = 0;
        viol   = 0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0; cnt <= 0; rdata <= '0; wl <= 1'b0; rl <= 1'b0; pend <= 1'b0;
        end else begin
            if (req && !done) begin
                if (pend && addr != paddr) viol <= viol + 1;
                pend  <= 1'b1;
                paddr <= addr;
                if (cnt == LAT) begin
                    done <= 1'b1;
                    cnt  <= 0;
                    if (prog) begin
                        mem[addr] <= mem[addr] | wdata;
                        if (prog_n < 16) begin
                            log_addr[prog_n] <= addr;
                            log_data[prog_n] <= wdata;
                        end
                        prog_n <= prog_n + 1;
                    end else begin
                        rdata <= mem[addr];
                        wl    <= (addr == 7'd5) || (addr == 7'd9);
                        rl    <= (addr == 7'd6);
                    end
                end else begin
                    cnt <= cnt + 1;
                end
            end else begin
                done <= 1'b0;
                pend <= 1'b0;
            end
        end
    end
endmodule

module test_otp_ctl_frontend;
    localparam logic [31:0] BAD = 32'hBADABADA;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic sel_a = 1'b0, sel_b = 1'b0;
    logic [31:0] rdata_a, rdata_b, timing_a, timing_b;
    logic req_a, prog_a, done_a, wl_a, rl_a, req_b, prog_b, done_b, wl_b, rl_b;
    logic [6:0] fa_a, fa_b;
    logic [31:0] fw_a, fw_b, fr_a, fr_b;
    int n_chk = 0, n_bad = 0, cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    otp_ctl_frontend #(.WORDS(16), .BANKED(0)) i_otp_ctl_frontend (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .fuse_req(req_a), .fuse_prog(prog_a),
        .fuse_addr(fa_a), .fuse_wdata(fw_a), .fuse_timing(timing_a), .fuse_done(done_a),
        .fuse_rdata(fr_a), .fuse_wlock(wl_a), .fuse_rlock(rl_a));
    otp_fuse_model #(.WORDS(16)) m_a (
        .clk(clk), .rst_n(rst_n), .req(req_a), .prog(prog_a), .addr(fa_a), .wdata(fw_a),
        .done(done_a), .rdata(fr_a), .wl(wl_a), .rl(rl_a));

    otp_ctl_frontend #(.WORDS(16), .BANKED(1)) i_otp_ctl_frontend_bk (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .fuse_req(req_b), .fuse_prog(prog_b),
        .fuse_addr(fa_b), .fuse_wdata(fw_b), .fuse_timing(timing_b), .fuse_done(done_b),
        .fuse_rdata(fr_b), .fuse_wlock(wl_b), .fuse_rlock(rl_b));
    otp_fuse_model #(.WORDS(16)) m_b (
        .clk(clk), .rst_n(rst_n), .req(req_b), .prog(prog_b), .addr(fa_b), .wdata(fw_b),
        .done(done_b), .rdata(fr_b), .wl(wl_b), .rl(rl_b));

    function automatic logic [31:0] initv(int i);
        return 32'h1000_0000 | (i << 8) | i;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit b, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (b) sel_b = 1'b1; else sel_a = 1'b1;
        @(posedge clk); #1;
        sel_a = 1'b0; sel_b = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(bit b, logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        if (b) sel_b = 1'b1; else sel_a = 1'b1;
        #2 d = b ? rdata_b : rdata_a;
        @(posedge clk); #1;
        sel_a = 1'b0; sel_b = 1'b0;
    endtask

    task automatic rd_chk(bit b, logic [11:0] a, logic [31:0] exp, string req);
        logic [31:0] v;
        rd(b, a, v);
        chk(req, v, exp);
    endtask

    task automatic wait_idle(bit b);
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(b, 12'h000, v);
            if (!v[8]) break;
        end
    endtask

    function automatic logic [11:0] sh(int i);
        return 12'h400 + 12'(i * 16);
    endfunction

    task automatic t_reset();
        rd_chk(0, 12'h000, 32'h0000_0500, "R1 busy+copy after reset");
        wait_idle(0);
        wait_idle(1);
        rd_chk(0, 12'h000, 32'h0, "R1 idle control word");
        rd_chk(0, sh(3), initv(3), "R2 shadow word 3");
        rd_chk(0, sh(15), initv(15), "R2 shadow word 15");
    endtask

    task automatic t_read_lock();
        rd_chk(0, sh(6), BAD, "R2 read-locked poison");
        rd_chk(0, 12'h000, 32'h0000_0200, "R2 error raised");
        rd_chk(0, sh(3), BAD, "R7 poison while error");
        wr(0, 12'h000, 32'h3E77_0004);
        rd_chk(0, 12'h000, 32'h0000_0200, "R7 control write ignored");
        wr(0, 12'h008, 32'h0000_0200);
        rd_chk(0, 12'h000, 32'h0, "R7 error cleared");
    endtask

    task automatic t_program();
        wr(0, 12'h000, 32'h3E77_0003);
        rd_chk(0, 12'h000, 32'h3E77_0003, "R3 key held");
        wr(0, 12'h020, 32'h0000_00F0);
        rd_chk(0, 12'h000, 32'h0000_0103, "R3 busy and key spent");
        wr(0, 12'h000, 32'h0000_0007);
        wait_idle(0);
        chk("R4 one request", 32'(m_a.prog_n), 32'd1);
        chk("R4 latched index", 32'(m_a.log_addr[0]), 32'd3);
        chk("R4 data", m_a.log_data[0], 32'h0000_00F0);
        rd_chk(0, sh(3), initv(3), "R8 shadow stale before copy");
        wr(0, 12'h004, 32'h0000_0400);
        rd_chk(0, 12'h000, 32'h0000_0507, "R8 copy running");
        wait_idle(0);
        rd_chk(0, sh(3), initv(3) | 32'hF0, "R8 shadow after copy");
    endtask

    task automatic t_no_key();
        wr(0, 12'h020, 32'h0000_0055);
        rd_chk(0, 12'h020, 32'h0000_0055, "R3 data stored");
        rd_chk(0, 12'h000, 32'h0000_0007, "R3 no busy without key");
        chk("R3 no request", 32'(m_a.prog_n), 32'd1);
    endtask

    task automatic t_locked();
        wr(0, 12'h000, 32'h3E77_0005);
        wr(0, 12'h020, 32'h0000_0001);
        rd_chk(0, 12'h000, 32'h0000_0205, "R6 error, no busy, key spent");
        chk("R6 no request", 32'(m_a.prog_n), 32'd1);
        wr(0, 12'h008, 32'h0000_0200);
        rd_chk(0, 12'h000, 32'h0000_0005, "R7 cleared");
    endtask

    task automatic t_overlap();
        wr(0, 12'h000, 32'h3E77_0004);
        wr(0, 12'h020, 32'h0000_0F00);
        wr(0, 12'h020, 32'h0000_FFFF);
        wr(0, 12'h004, 32'h0000_0400);
        wait_idle(0);
        rd_chk(0, 12'h000, 32'h0000_0204, "R9 overlap error");
        rd_chk(0, 12'h020, 32'h0000_0F00, "R9 data kept");
        chk("R9 single request", 32'(m_a.prog_n), 32'd2);
        chk("R9 request index", 32'(m_a.log_addr[1]), 32'd4);
        chk("R9 request data", m_a.log_data[1], 32'h0000_0F00);
        wr(0, 12'h008, 32'h0000_0200);
    endtask

    task automatic t_shadow_write();
        wr(0, sh(2), 32'h1234_5678);
        rd_chk(0, sh(2), 32'h1234_5678, "R10 shadow write");
        wr(0, sh(5), 32'hFFFF_0000);
        rd_chk(0, 12'h000, 32'h0000_0204, "R10 locked shadow error");
        wr(0, 12'h008, 32'h0000_0200);
        rd_chk(0, sh(5), initv(5), "R10 locked word unchanged");
        wr(0, 12'h004, 32'h0000_0400);
        wr(0, sh(2), 32'h0000_DEAD);
        rd_chk(0, 12'h000, 32'h0000_0704, "R10 write during copy error");
        wait_idle(0);
        wr(0, 12'h008, 32'h0000_0200);
        rd_chk(0, sh(2), initv(2), "R8 copy restores word");
        rd_chk(0, sh(4), initv(4) | 32'h0F00, "R8 programmed bits visible");
    endtask

    task automatic t_timing();
        wr(0, 12'h010, 32'h00AB_C123);
        rd_chk(0, 12'h010, 32'h00AB_C123, "R12 readback");
        chk("R12 port", timing_a, 32'h00AB_C123);
    endtask

    task automatic t_banked();
        wr(1, 12'h030, 32'h11);
        wr(1, 12'h040, 32'h22);
        wr(1, 12'h050, 32'h33);
        wr(1, 12'h000, 32'h3E77_0000);
        wr(1, 12'h020, 32'h44);
        wait_idle(1);
        chk("R11 four requests", 32'(m_b.prog_n), 32'd4);
        for (int k = 0; k < 4; k++)
            chk("R11 word order", 32'(m_b.log_addr[k]), 32'(k));
        chk("R11 word0 data", m_b.log_data[0], 32'h44);
        chk("R11 word1 data", m_b.log_data[1], 32'h11);
        chk("R11 word2 data", m_b.log_data[2], 32'h22);
        chk("R11 word3 data", m_b.log_data[3], 32'h33);
        rd_chk(1, 12'h030, 32'h11, "R11 stage readback");
        wr(1, 12'h000, 32'h3E77_0002);
        wr(1, 12'h020, 32'h1);
        rd_chk(1, 12'h000, 32'h0000_0202, "R11 locked group error");
        chk("R11 no extra request", 32'(m_b.prog_n), 32'd4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_read_lock();
        t_program();
        t_no_key();
        t_locked();
        t_overlap();
        t_shadow_write();
        t_timing();
        t_banked();
        chk("R5 handshake hold A", 32'(m_a.viol), 32'd0);
        chk("R5 handshake hold B", 32'(m_b.viol), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cycles == 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule